// File: doc/BRIEF.md
# Decode-Stage Branch Hazard Unit

This block sits in the decode stage of a five-stage in-order pipeline that resolves conditional branches in decode. A branch compares its two source registers there, one cycle after fetch, so only the single instruction fetched behind it is wasted when the branch is taken. Because the compare happens so early, the block must supply its own forwarding for the comparator and must hold the pipeline when an operand is still being computed.

The block is purely combinational. It reads the source register numbers of the instruction in decode, the destination number and write flags of the instructions in execute and memory, the decoded branch and jump flags, and the comparator outcome. It produces one select per comparator operand, write enables for the program counter and the fetch/decode register, a bubble request that clears the control bits entering execute, and a flush that turns the fetched instruction into a no-op.

Top module: `branch_hazard_unit`

## Requirements
- R1: `fwd_a_sel` is 1 exactly when `id_is_branch` is 1, `mem_reg_write` is 1, `mem_mem_read` is 0, `mem_rd` is nonzero and `mem_rd` equals `id_rs`.
- R2: `fwd_b_sel` follows the rule of R1 with `id_rt` in place of `id_rs`.
- R3: A producer that has left the memory stage no longer appears on the block's inputs, so it causes neither forwarding nor a stall. Its value reaches the branch through the register file, which writes before it reads in the same cycle.
- R4: A branch in decode whose `id_rs` or `id_rt` equals a nonzero `ex_rd` with `ex_reg_write` set drives `pc_write_en` and `ifid_write_en` to 0. Otherwise both are 1.
- R5: `idex_bubble` is 1 in exactly the cycles in which R4 or R8 holds the pipeline.
- R6: A branch that is not held drives `if_flush` to 1 when `id_br_taken` is 1, and to 0 when it is 0.
- R7: A jump in decode drives `if_flush` to 1 for that one cycle and never holds the pipeline.
- R8: A load in memory (`mem_mem_read` and `mem_reg_write` set, nonzero `mem_rd` matching a branch source) also holds the pipeline. A load that is in execute when its dependent branch reaches decode therefore holds the branch for exactly two cycles.
- R9: A hold overrides the branch decision: `if_flush` is 0 in every held cycle, whatever `id_br_taken` is.
- R10: Register 0 as a destination never causes forwarding or a hold.
- R11: When neither `id_is_branch` nor `id_is_jump` is set, all outputs sit at their idle values: selects 0, write enables 1, bubble 0, flush 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_is_branch | input | 1 | Instruction in decode is a conditional branch |
| id_is_jump | input | 1 | Instruction in decode is an unconditional jump |
| id_br_taken | input | 1 | Comparator outcome for the branch in decode |
| id_rs | input | REG_W | First source register of the decode instruction |
| id_rt | input | REG_W | Second source register of the decode instruction |
| ex_rd | input | REG_W | Destination of the instruction in execute |
| ex_reg_write | input | 1 | Instruction in execute writes a register |
| mem_rd | input | REG_W | Destination of the instruction in memory |
| mem_reg_write | input | 1 | Instruction in memory writes a register |
| mem_mem_read | input | 1 | Instruction in memory is a load |
| fwd_a_sel | output | 1 | First comparator operand taken from the memory-stage result |
| fwd_b_sel | output | 1 | Second comparator operand taken from the memory-stage result |
| pc_write_en | output | 1 | Program counter may update |
| ifid_write_en | output | 1 | Fetch/decode register may update |
| idex_bubble | output | 1 | Zero the control bits entering execute |
| if_flush | output | 1 | Clear the instruction field of the fetch/decode register |

## Verification
Every output is a same-cycle function of the inputs, so each table vector is driven on a falling edge and all six outputs are sampled one nanosecond later, before the next rising edge. The multi-cycle behaviour depends on the pipeline registers, which are modelled in the bench. A harness advances them on each clock, inserting a bubble in execute and holding decode whenever `pc_write_en` is low. From that harness the checks expect two held cycles behind a load in execute and one behind an arithmetic producer. They expect forwarding in the cycle the hold is released after the arithmetic producer, and a flush only in the cycle the branch finally resolves.

// File: rtl/bhz_pkg.sv
package bhz_pkg;

    typedef struct packed {
        logic fwd_a;
        logic fwd_b;
        logic pc_we;
        logic ifid_we;
        logic bubble;
        logic flush;
    } hz_ctl_t;

    localparam int unsigned NUM_SRC = 2;

endpackage

// File: rtl/bhz_fwd_sel.sv
module bhz_fwd_sel #(
    parameter int unsigned REG_W = 5
) (
    input  logic             is_branch,
    input  logic [REG_W-1:0] src_reg,
    input  logic [REG_W-1:0] mem_rd,
    input  logic             mem_reg_write,
    input  logic             mem_mem_read,
    output logic             sel
);

    always_comb begin
        sel = is_branch && mem_reg_write && !mem_mem_read
              && (mem_rd != '0) && (mem_rd == src_reg);
    end

endmodule

// File: rtl/bhz_stall_det.sv
module bhz_stall_det #(
    parameter int unsigned REG_W   = 5,
    parameter int unsigned NUM_SRC = 2
) (
    input  logic             is_branch,
    input  logic [REG_W-1:0] src_regs [NUM_SRC],
    input  logic [REG_W-1:0] ex_rd,
    input  logic             ex_reg_write,
    input  logic [REG_W-1:0] mem_rd,
    input  logic             mem_reg_write,
    input  logic             mem_mem_read,
    output logic             stall
);

    logic [NUM_SRC-1:0] ex_hit;
    logic [NUM_SRC-1:0] ld_hit;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        assign ex_hit[g] = ex_reg_write && (ex_rd != '0) && (ex_rd == src_regs[g]);
        assign ld_hit[g] = mem_mem_read && mem_reg_write && (mem_rd != '0)
                           && (mem_rd == src_regs[g]);
    end

    always_comb begin
        stall = is_branch && ((|ex_hit) || (|ld_hit));
    end

endmodule

// File: rtl/bhz_flow_ctl.sv
module bhz_flow_ctl (
    input  logic stall,
    input  logic is_branch,
    input  logic is_jump,
    input  logic br_taken,
    output logic pc_we,
    output logic ifid_we,
    output logic bubble,
    output logic flush
);

    always_comb begin
        pc_we   = !stall;
        ifid_we = !stall;
        bubble  = stall;
        // a held branch has no valid decision yet
        flush   = !stall && (is_jump || (is_branch && br_taken));
    end

endmodule

// File: rtl/branch_hazard_unit.sv
module branch_hazard_unit
    import bhz_pkg::*;
#(
    parameter int unsigned REG_W = 5
) (
    input  logic             id_is_branch,
    input  logic             id_is_jump,
    input  logic             id_br_taken,
    input  logic [REG_W-1:0] id_rs,
    input  logic [REG_W-1:0] id_rt,
    input  logic [REG_W-1:0] ex_rd,
    input  logic             ex_reg_write,
    input  logic [REG_W-1:0] mem_rd,
    input  logic             mem_reg_write,
    input  logic             mem_mem_read,
    output logic             fwd_a_sel,
    output logic             fwd_b_sel,
    output logic             pc_write_en,
    output logic             ifid_write_en,
    output logic             idex_bubble,
    output logic             if_flush
);

    logic [REG_W-1:0] src_regs [NUM_SRC];
    logic [NUM_SRC-1:0] fwd_sel;
    logic stall;
    logic pc_we, ifid_we, bubble, flush;
    hz_ctl_t ctl_d;

    assign src_regs[0] = id_rs;
    assign src_regs[1] = id_rt;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_fwd
        bhz_fwd_sel #(.REG_W(REG_W)) u_fwd (
            .is_branch     (id_is_branch),
            .src_reg       (src_regs[g]),
            .mem_rd        (mem_rd),
            .mem_reg_write (mem_reg_write),
            .mem_mem_read  (mem_mem_read),
            .sel           (fwd_sel[g])
        );
    end

    bhz_stall_det #(.REG_W(REG_W), .NUM_SRC(NUM_SRC)) u_stall (
        .is_branch     (id_is_branch),
        .src_regs      (src_regs),
        .ex_rd         (ex_rd),
        .ex_reg_write  (ex_reg_write),
        .mem_rd        (mem_rd),
        .mem_reg_write (mem_reg_write),
        .mem_mem_read  (mem_mem_read),
        .stall         (stall)
    );

    bhz_flow_ctl u_flow (
        .stall     (stall),
        .is_branch (id_is_branch),
        .is_jump   (id_is_jump),
        .br_taken  (id_br_taken),
        .pc_we     (pc_we),
        .ifid_we   (ifid_we),
        .bubble    (bubble),
        .flush     (flush)
    );

    always_comb begin
        ctl_d.fwd_a   = fwd_sel[0];
        ctl_d.fwd_b   = fwd_sel[1];
        ctl_d.pc_we   = pc_we;
        ctl_d.ifid_we = ifid_we;
        ctl_d.bubble  = bubble;
        ctl_d.flush   = flush;
    end

    assign fwd_a_sel     = ctl_d.fwd_a;
    assign fwd_b_sel     = ctl_d.fwd_b;
    assign pc_write_en   = ctl_d.pc_we;
    assign ifid_write_en = ctl_d.ifid_we;
    assign idex_bubble   = ctl_d.bubble;
    assign if_flush      = ctl_d.flush;

    // checks across the separately built pieces
    always_comb begin
        if (ctl_d.flush) begin
            a_r9_flush_only_when_moving: assert (ctl_d.pc_we && ctl_d.ifid_we)
                else $error("flush while pipeline held");
        end
        if (ctl_d.bubble) begin
            a_r5_bubble_with_hold: assert (!ctl_d.pc_we && !ctl_d.ifid_we)
                else $error("bubble without hold");
        end
        if (mem_rd == '0) begin
            a_r10_zero_never_forwards: assert (!ctl_d.fwd_a && !ctl_d.fwd_b)
                else $error("forward from register 0");
        end
        if (ex_rd == '0 && mem_rd == '0) begin
            a_r10_zero_never_holds: assert (!stall)
                else $error("hold on register 0");
        end
        if (!id_is_branch) begin
            a_r11_no_branch_no_hazard: assert (!ctl_d.fwd_a && !ctl_d.fwd_b && !ctl_d.bubble)
                else $error("hazard action without branch");
        end
        if (ctl_d.fwd_a || ctl_d.fwd_b) begin
            a_r1_fwd_not_with_load: assert (!mem_mem_read)
                else $error("forwarding a load result");
        end
    end

endmodule

// File: tb/test_branch_hazard_unit.sv
module test_branch_hazard_unit;

    localparam int unsigned REG_W = 5;

    typedef struct packed {
        logic [3:0]       req;
        logic             br;
        logic             jmp;
        logic             tkn;
        logic [REG_W-1:0] rs;
        logic [REG_W-1:0] rt;
        logic [REG_W-1:0] exd;
        logic             exw;
        logic [REG_W-1:0] mmd;
        logic             mmw;
        logic             mmr;
        logic [5:0]       exp; // fwd_a fwd_b pc_we ifid_we bubble flush
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{4'd11, 1'b0, 1'b0, 1'b0, 5'd0, 5'd0, 5'd0, 1'b0, 5'd0, 1'b0, 1'b0, 6'b001100}, // R11 idle
        '{4'd1,  1'b1, 1'b0, 1'b0, 5'd1, 5'd2, 5'd4, 1'b1, 5'd1, 1'b1, 1'b0, 6'b101100}, // R1
        '{4'd2,  1'b1, 1'b0, 1'b0, 5'd1, 5'd2, 5'd4, 1'b1, 5'd2, 1'b1, 1'b0, 6'b011100}, // R2
        '{4'd2,  1'b1, 1'b0, 1'b0, 5'd3, 5'd3, 5'd0, 1'b0, 5'd3, 1'b1, 1'b0, 6'b111100}, // R1 R2 both
        '{4'd10, 1'b1, 1'b0, 1'b0, 5'd0, 5'd5, 5'd0, 1'b1, 5'd0, 1'b1, 1'b0, 6'b001100}, // R10 mem
        '{4'd4,  1'b1, 1'b0, 1'b0, 5'd1, 5'd2, 5'd1, 1'b1, 5'd0, 1'b0, 1'b0, 6'b000010}, // R4 rs
        '{4'd9,  1'b1, 1'b0, 1'b1, 5'd1, 5'd2, 5'd2, 1'b1, 5'd0, 1'b0, 1'b0, 6'b000010}, // R9 R4 rt
        '{4'd8,  1'b1, 1'b0, 1'b0, 5'd1, 5'd2, 5'd0, 1'b0, 5'd2, 1'b1, 1'b1, 6'b000010}, // R8 load in mem
        '{4'd6,  1'b1, 1'b0, 1'b1, 5'd1, 5'd2, 5'd0, 1'b0, 5'd0, 1'b0, 1'b0, 6'b001101}, // R6 taken
        '{4'd6,  1'b1, 1'b0, 1'b0, 5'd1, 5'd2, 5'd7, 1'b1, 5'd9, 1'b1, 1'b0, 6'b001100}, // R6 not taken
        '{4'd7,  1'b0, 1'b1, 1'b0, 5'd7, 5'd0, 5'd7, 1'b1, 5'd7, 1'b1, 1'b1, 6'b001101}, // R7 jump
        '{4'd11, 1'b0, 1'b0, 1'b1, 5'd1, 5'd1, 5'd1, 1'b1, 5'd1, 1'b1, 1'b0, 6'b001100}, // R11 matches, no branch
        '{4'd4,  1'b1, 1'b0, 1'b0, 5'd6, 5'd2, 5'd6, 1'b0, 5'd0, 1'b0, 1'b0, 6'b001100}, // R4 no write
        '{4'd10, 1'b1, 1'b0, 1'b1, 5'd0, 5'd3, 5'd0, 1'b1, 5'd0, 1'b0, 1'b0, 6'b001101}, // R10 ex
        '{4'd1,  1'b1, 1'b0, 1'b0, 5'd8, 5'd2, 5'd0, 1'b0, 5'd8, 1'b0, 1'b0, 6'b001100}  // R1 no write
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic             br, jmp, tkn, exw, mmw, mmr;
    logic [REG_W-1:0] rs, rt, exd, mmd;
    logic fa, fb, pcw, ifw, bub, fl;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    branch_hazard_unit #(.REG_W(REG_W)) i_branch_hazard_unit (
        .id_is_branch  (br),
        .id_is_jump    (jmp),
        .id_br_taken   (tkn),
        .id_rs         (rs),
        .id_rt         (rt),
        .ex_rd         (exd),
        .ex_reg_write  (exw),
        .mem_rd        (mmd),
        .mem_reg_write (mmw),
        .mem_mem_read  (mmr),
        .fwd_a_sel     (fa),
        .fwd_b_sel     (fb),
        .pc_write_en   (pcw),
        .ifid_write_en (ifw),
        .idex_bubble   (bub),
        .if_flush      (fl)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int outs();
        return int'({fa, fb, pcw, ifw, bub, fl});
    endfunction

    task automatic clear_pipe();
        br = 0; jmp = 0; tkn = 0; rs = '0; rt = '0;
        exd = '0; exw = 0; mmd = '0; mmw = 0; mmr = 0;
    endtask

    // harness: one clock of pipeline advance given the sampled hold
    task automatic advance_held();
        mmd = exd; mmw = exw; mmr = 1'b0;
        exd = '0;  exw = 1'b0;
    endtask

    initial begin
        #100000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int held;
        logic ld_in_mem;
        clear_pipe();
        repeat (2) @(negedge clk);
        #1;
        // reset state: idle outputs (R11, R5)
        chk("R11 reset outputs", outs(), 6'b001100);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            br = VECS[i].br;   jmp = VECS[i].jmp; tkn = VECS[i].tkn;
            rs = VECS[i].rs;   rt = VECS[i].rt;
            exd = VECS[i].exd; exw = VECS[i].exw;
            mmd = VECS[i].mmd; mmw = VECS[i].mmw; mmr = VECS[i].mmr;
            #1;
            chk($sformatf("R%0d vector %0d", VECS[i].req, i), outs(), int'(VECS[i].exp));
        end

        // R8: load in execute, taken branch on its destination
        @(negedge clk);
        clear_pipe();
        exd = 5'd3; exw = 1; br = 1; rs = 5'd3; rt = 5'd4; tkn = 1;
        ld_in_mem = 1'b1;
        held = 0;
        for (int c = 0; c < 5; c++) begin
            #1;
            if (pcw) break;
            held++;
            chk("R9 no flush while held", int'(fl), 0);
            @(posedge clk);
            mmd = exd; mmw = exw; mmr = ld_in_mem;
            ld_in_mem = 1'b0;
            exd = '0; exw = 1'b0;
            @(negedge clk);
        end
        chk("R8 load hold cycles", held, 2);
        chk("R3 no forward after load leaves", int'(fa), 0);
        chk("R6 flush on release", int'(fl), 1);

        // R4: arithmetic producer in execute holds once, then forwards
        @(negedge clk);
        clear_pipe();
        exd = 5'd3; exw = 1; br = 1; rs = 5'd9; rt = 5'd3; tkn = 0;
        held = 0;
        for (int c = 0; c < 5; c++) begin
            #1;
            if (pcw) break;
            held++;
            chk("R5 bubble while held", int'(bub), 1);
            @(posedge clk);
            advance_held();
            @(negedge clk);
        end
        chk("R4 alu hold cycles", held, 1);
        chk("R2 forward on release", int'(fb), 1);
        chk("R6 no flush not taken", int'(fl), 0);

        // R7: jump flushes one cycle only
        @(negedge clk);
        clear_pipe();
        jmp = 1; exd = 5'd2; exw = 1;
        #1;
        chk("R7 jump flush", int'(fl), 1);
        chk("R7 jump no hold", int'(pcw), 1);
        @(negedge clk);
        jmp = 0;
        #1;
        chk("R7 flush single cycle", int'(fl), 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule